// File: doc/BRIEF.md
# Coefficient Dequantiser with Early Valid

The block sits between an entropy decoder and an inverse transform in an image decompression pipeline. It takes quantised transform coefficients one at a time, 64 per 8x8 block, and scales each by the entry of a fixed quantisation matrix that matches the coefficient's position in the block. The scaled value is passed downstream as a signed 16-bit number that is clamped at its range limits.

The output strobe leads the data by one clock cycle. The downstream stage sees that a value is coming one cycle before the value appears, so it can prepare to capture it. The downstream request line is not used by the block. It goes straight through to the upstream stage as its request.

Top module: `coef_dequantiser`

## Requirements
- R1: For every accepted coefficient c at block position k, the block emits the value c multiplied by the matrix entry q(k). The entry is q(k) = 2 + 3*(row+col) + row, where row = k/8 and col = k%8.
- R2: A position counter starts at 0, advances by one on each accepted input, and returns to 0 after position 63. Coefficient 64 of a stream therefore uses entry q(0).
- R3: A coefficient of zero gives an output of exactly zero.
- R4: The strobe `prod_early_vld` is high for exactly one cycle per accepted input, in the cycle after the input edge. The matching product appears on `prod_out` in the next cycle.
- R5: `req_to_up` equals `req_from_down` at all times, with no register between them.
- R6: A product above 32767 is output as 32767. A product below -32768 is output as -32768.
- R7: A synchronous active-low reset clears the position counter, the strobe and `prod_out` to zero. The first input after reset uses entry q(0).
- R8: A cycle with `coef_in_vld` low neither advances the position counter nor produces a strobe.
- R9: `prod_out` keeps its last value in every cycle that does not follow a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| coef_in | input | 12 | Signed quantised coefficient |
| coef_in_vld | input | 1 | Qualifies `coef_in` for the current cycle |
| req_from_down | input | 1 | Request from the downstream stage |
| req_to_up | output | 1 | Request passed on to the upstream stage |
| prod_out | output | 16 | Signed, saturated dequantised coefficient |
| prod_early_vld | output | 1 | High one cycle before a new `prod_out` value |

## Verification
The assertions are checked on every cycle for the following behaviours:
- the counter wraps from 63 to 0 and holds during idle cycles;
- a zero input leads to a zero output, and a saturated result keeps the sign of its input;
- `prod_out` is stable when no strobe came before;
- reset clears the outputs.

Some behaviours can only be shown by the bench's scenarios, which compare against the matrix formula. These are:
- the actual product values at each block position;
- where the wrap falls in a long stream and in a stream with gaps;
- the exact one-cycle lead of the strobe over its data;
- the restart of the position count after a reset in the middle of a block.

// File: rtl/dq_pkg.sv
`timescale 1ns/1ps
// Package dq_pkg
// Holds the block geometry and the rule that computes the hardwired
// quantisation matrix. Assumes square blocks of BLK_SIDE x BLK_SIDE.
package dq_pkg;
    localparam int BLK_SIDE = 8;
    localparam int BLK_LEN  = BLK_SIDE * BLK_SIDE;

    // Matrix entry for a raster position: grows toward high frequencies.
    function automatic logic [7:0] qmat_entry(input int pos);
        int row;
        int col;
        row = pos / BLK_SIDE;
        col = pos % BLK_SIDE;
        return 8'(2 + 3 * (row + col) + row);
    endfunction
endpackage

// File: rtl/dq_index_counter.sv
`timescale 1ns/1ps
// Module dq_index_counter
// Tracks the position of the next coefficient inside its block.
// Assumes one accepted coefficient per cycle at most (adv is a pulse per item).
module dq_index_counter #(
    parameter int LEN   = 64,
    localparam int IDX_W = $clog2(LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

    // Advance on each accepted item, wrap after the last position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (adv)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

    // R2: the last position is followed by position zero
    a_r2_wraps_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && idx == LAST) |=> idx == '0);

    // R8: no accepted item, no movement
    a_r8_holds_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx));
endmodule

// File: rtl/dq_matrix_rom.sv
`timescale 1ns/1ps
// Module dq_matrix_rom
// Fixed quantisation matrix, one entry per block position, read
// combinationally. Entries are computed at elaboration from dq_pkg.
module dq_matrix_rom #(
    parameter int LEN   = 64,
    parameter int QW    = 8,
    localparam int IDX_W = $clog2(LEN)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [QW-1:0]    q
);
    logic [QW-1:0] table_q [LEN];

    // One constant driver per matrix entry.
    for (genvar k = 0; k < LEN; k++) begin : g_entry
        assign table_q[k] = QW'(dq_pkg::qmat_entry(k));
    end

    // Select the entry of the current position.
    always_comb q = table_q[idx];
endmodule

// File: rtl/dq_sat_mul.sv
`timescale 1ns/1ps
// Module dq_sat_mul
// Signed coefficient times unsigned matrix entry, clamped to a signed
// OUT_W-bit range. Purely combinational; the caller registers the result.
module dq_sat_mul #(
    parameter int COEF_W = 12,
    parameter int QW     = 8,
    parameter int OUT_W  = 16
) (
    input  logic signed [COEF_W-1:0] coef,
    input  logic        [QW-1:0]     q,
    output logic signed [OUT_W-1:0]  res
);
    localparam int PW = COEF_W + QW + 1;
    localparam logic signed [PW-1:0] MAXV = {{(PW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = {{(PW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [PW-1:0] full;

    // Exact product at full width, then clamp to the output range.
    always_comb begin
        full = $signed({{(PW-COEF_W){coef[COEF_W-1]}}, coef})
             * $signed({{(PW-QW){1'b0}}, q});
        if (full > MAXV)
            res = MAXV[OUT_W-1:0];
        else if (full < MINV)
            res = MINV[OUT_W-1:0];
        else
            res = full[OUT_W-1:0];
    end

    // R6: clamping never flips the sign of a non-zero product
    always_comb begin
        if (coef != '0 && q != '0)
            a_r6_sign_kept: assert (res[OUT_W-1] == coef[COEF_W-1]);
    end
endmodule

// File: rtl/coef_dequantiser.sv
`timescale 1ns/1ps
// Module coef_dequantiser
// Scales a stream of quantised coefficients by a hardwired matrix.
// Stage 1 captures the coefficient and its matrix entry; stage 2 holds
// the saturated product. The strobe comes from stage 1, so it leads
// the data by one cycle. Assumes coefficients arrive in the same
// order the matrix is indexed.
module coef_dequantiser #(
    parameter int COEF_W = 12,
    parameter int QW     = 8,
    parameter int OUT_W  = 16,
    parameter int LEN    = dq_pkg::BLK_LEN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [COEF_W-1:0] coef_in,
    input  logic                     coef_in_vld,
    input  logic                     req_from_down,
    output logic                     req_to_up,
    output logic signed [OUT_W-1:0]  prod_out,
    output logic                     prod_early_vld
);
    localparam int IDX_W = $clog2(LEN);

    logic [IDX_W-1:0]         pos;
    logic [QW-1:0]            q_cur;
    logic                     s1_vld;
    logic signed [COEF_W-1:0] s1_coef;
    logic [QW-1:0]            s1_q;
    logic signed [OUT_W-1:0]  prod_next;

    dq_index_counter #(.LEN(LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (coef_in_vld),
        .idx   (pos)
    );

    dq_matrix_rom #(.LEN(LEN), .QW(QW)) u_rom (
        .idx (pos),
        .q   (q_cur)
    );

    dq_sat_mul #(.COEF_W(COEF_W), .QW(QW), .OUT_W(OUT_W)) u_mul (
        .coef (s1_coef),
        .q    (s1_q),
        .res  (prod_next)
    );

    // Request from downstream passes straight to upstream.
    assign req_to_up = req_from_down;

    // Stage 1: capture coefficient and its matrix entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_coef <= '0;
            s1_q    <= '0;
        end else begin
            s1_vld <= coef_in_vld;
            if (coef_in_vld) begin
                s1_coef <= coef_in;
                s1_q    <= q_cur;
            end
        end
    end

    // Stage 2: hold the product; updates only behind a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prod_out <= '0;
        else if (s1_vld)
            prod_out <= prod_next;
    end

    assign prod_early_vld = s1_vld;

    // R3: a zero coefficient in stage 1 lands as zero
    a_r3_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_coef == '0) |=> prod_out == '0);

    // R9: output unchanged when no strobe preceded
    a_r9_holds_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_early_vld |=> $stable(prod_out));

    // R4: strobe follows an accepted input by one cycle
    a_r4_strobe_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        coef_in_vld |=> prod_early_vld);

    // R7: reset leaves strobe and output cleared
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!prod_early_vld && prod_out == '0));
endmodule

// File: tb/coef_dequantiser_bench.sv
`timescale 1ns/1ps
module coef_dequantiser_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [11:0] coef_in = '0;
    logic coef_in_vld = 1'b0;
    logic req_from_down = 1'b0;
    logic req_to_up;
    logic signed [15:0] prod_out;
    logic prod_early_vld;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    coef_dequantiser u_coef_dequantiser (
        .clk(clk), .rst_n(rst_n), .coef_in(coef_in), .coef_in_vld(coef_in_vld),
        .req_from_down(req_from_down), .req_to_up(req_to_up),
        .prod_out(prod_out), .prod_early_vld(prod_early_vld)
    );

    // Bench model of the expected stream
    int    exp_q[$];
    string tag_q[$];
    int    bidx = 0;
    bit    mon_on = 0;
    bit    pend = 0;
    int    pend_val = 0;
    string pend_tag = "";
    int    last_prod = 0;

    function automatic int qent(int k);
        return 2 + 3 * ((k / 8) + (k % 8)) + (k / 8);
    endfunction

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Streaming monitor: data one cycle after each strobe, hold otherwise
    always @(negedge clk) begin
        if (mon_on) begin
            if (pend) begin
                chk(int'(prod_out) == pend_val, pend_tag, int'(prod_out), pend_val);
                last_prod = pend_val;
            end else begin
                chk(int'(prod_out) == last_prod, "R9 hold", int'(prod_out), last_prod);
            end
            if (prod_early_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected strobe", 1, 0);
                    pend = 0;
                end else begin
                    pend_val = exp_q.pop_front();
                    pend_tag = tag_q.pop_front();
                    pend = 1;
                end
            end else begin
                pend = 0;
            end
        end
    end

    task automatic send(int c, string tag);
        @(negedge clk);
        coef_in = 12'(c);
        coef_in_vld = 1'b1;
        exp_q.push_back(sat16(c * qent(bidx)));
        tag_q.push_back(tag);
        bidx = (bidx + 1) % 64;
    endtask

    task automatic idle();
        @(negedge clk);
        coef_in_vld = 1'b0;
        coef_in = '0;
    endtask

    task automatic drain(string tag);
        idle();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0 && !pend, tag, exp_q.size(), 0);
    endtask

    // R7: reset state and counter restart
    task automatic do_reset();
        mon_on = 0;
        @(negedge clk);
        rst_n = 1'b0;
        coef_in_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk(prod_early_vld == 1'b0, "R7 strobe in reset", int'(prod_early_vld), 0);
        chk(prod_out == '0, "R7 data in reset", int'(prod_out), 0);
        exp_q.delete();
        tag_q.delete();
        bidx = 0;
        pend = 0;
        last_prod = 0;
        rst_n = 1'b1;
        mon_on = 1;
    endtask

    // R4: strobe exactly one cycle before its data
    task automatic t_strobe_lead();
        do_reset();
        send(300, "R4 lead data");
        idle();
        chk(prod_early_vld == 1'b1, "R4 strobe early", int'(prod_early_vld), 1);
        chk(int'(prod_out) == 0, "R4 data not yet", int'(prod_out), 0);
        @(negedge clk);
        chk(prod_early_vld == 1'b0, "R4 strobe single", int'(prod_early_vld), 0);
        chk(int'(prod_out) == 600, "R4 data arrives", int'(prod_out), 600);
        drain("R4 drained");
    endtask

    // R5: request passthrough
    task automatic t_request();
        req_from_down = 1'b1;
        #1;
        chk(req_to_up == 1'b1, "R5 request high", int'(req_to_up), 1);
        req_from_down = 1'b0;
        #1;
        chk(req_to_up == 1'b0, "R5 request low", int'(req_to_up), 0);
    endtask

    // R1: a full block of varied values
    task automatic t_ramp_block();
        do_reset();
        for (int k = 0; k < 64; k++) send(k * 7 - 200, "R1 ramp");
        drain("R1 drained");
    endtask

    // R3: zeros mixed with non-zeros
    task automatic t_zeros();
        do_reset();
        for (int k = 0; k < 20; k++) send((k % 3 == 0) ? -5 : 0, "R3 zero");
        drain("R3 drained");
    endtask

    // R2: stream crossing a block boundary
    task automatic t_wrap();
        do_reset();
        for (int k = 0; k < 70; k++) send(k - 35, "R2 wrap");
        drain("R2 drained");
    endtask

    // R6: extremes saturate at both limits
    task automatic t_saturate();
        do_reset();
        for (int k = 0; k < 64; k++) send((k % 2 == 0) ? 2047 : -2048, "R6 saturate");
        drain("R6 drained");
    endtask

    // R8: gaps do not move the position
    task automatic t_gaps();
        do_reset();
        for (int k = 0; k < 30; k++) begin
            send(11 * k - 90, "R8 gaps");
            for (int g = 0; g < (k % 3); g++) idle();
        end
        drain("R8 drained");
    endtask

    // R7: reset mid-block restarts at position zero
    task automatic t_mid_reset();
        do_reset();
        for (int k = 0; k < 10; k++) send(100 + k, "R7 pre-reset");
        idle();
        do_reset();
        send(1000, "R7 first after reset");
        send(1000, "R7 second after reset");
        drain("R7 drained");
    endtask

    initial begin
        t_strobe_lead();
        t_request();
        t_ramp_block();
        t_zeros();
        t_wrap();
        t_saturate();
        t_gaps();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            chk(1'b0, "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule